// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler

This peripheral watches for a stalled system. A prescaler divides the input clock into a periodic tick. An elapsed-tick counter advances on each tick while the watchdog is armed. When the counter matches a software-programmed timeout, the block can issue a one-cycle reset request. Software keeps the system alive by writing to a restart register before the timeout is reached. Any data value counts as a restart.

Software reaches the block through three 32-bit registers on a simple bus. The bus has an address, a write strobe, write data and a combinational read-data return. The control register holds the divide value and four enable flags. Setting the divide value to the clock rate divided by 1000 gives a 1 ms tick. The timeout register holds the timeout in ticks in its low half, and its high half returns the live elapsed count, which is read-only. Remaining time is the timeout minus the elapsed count.

The sequencing is a three-state machine:
- OFF: the watchdog is disarmed.
- RUN: the watchdog is armed and comparing.
- FIRE: one expiry cycle, during which the request pulse may be driven and after which the elapsed count clears.

The transitions are:
- OFF to RUN when the enable flag is set.
- RUN to OFF when the enable flag is cleared.
- RUN to RUN on a restart write, or while the elapsed count differs from the timeout.
- RUN to FIRE when the elapsed count equals the timeout and no restart write is present.
- FIRE to RUN if the enable flag is still set, otherwise FIRE to OFF.

Top module: `wdog_timer`

## Requirements
- R1: After reset, all three registers read zero and `rst_req` is low.
- R2: The control register is at offset 0x0. Its bits are placed as follows:
  - bits 17:0 hold the divide value;
  - bit 18 arms the watchdog;
  - bit 21 permits the reset request;
  - bit 24 is the clock enable;
  - bit 25 is the divider enable.
  All other bits read zero. Rewriting the register with only bit 18 changed leaves the other fields as written.
- R3: The timeout register is at offset 0x8. Bits 15:0 are the software timeout in ticks. Bits 31:16 return the elapsed count, and writes to them are ignored.
- R4: A write of any data to offset 0xC clears the elapsed count to zero at that clock edge.
- R5: A tick occurs once every divide-value cycles, and only while both the clock enable and the divider enable are set. With either one clear, the elapsed count does not advance.
- R6: While armed, the elapsed count rises by one per tick, starting from zero. When the control write that arms the block also sets both enables and takes a divide value D of 3 or more with timeout T, the first request pulse appears T*D+1 cycles after that write edge.
- R7: On expiry the request is exactly one cycle wide when bit 21 is set, and the elapsed count then clears. Consecutive pulses are T*D cycles apart (for D of 3 or more).
- R8: With bit 21 clear, expiry drives no pulse, but the elapsed count still clears.
- R9: While disarmed, the elapsed count holds its value and no request is produced.
- R10: When a restart write lands in the same cycle as a match between the elapsed count and the timeout, the restart wins. No pulse is produced and counting starts again from zero.
- R11: Reads of any offset other than 0x0 and 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A restart write and an expiry can meet in the same cycle, and the priority between them is the riskiest behaviour. The bench creates this case by arming the watchdog with a divide value of 5 and a timeout of 2. It then issues the restart write so that it lands on the edge that follows the cycle in which the elapsed count first equals the timeout. The bench judges the result by requiring that no pulse appears in the next cycle and that the first pulse arrives exactly ten cycles after the restart edge. Sweeps over small divide values and timeouts separately pin down the exact cycle of each pulse and the spacing between pulses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_RUN  = 2'd1,
        S_FIRE = 2'd2
    } wd_state_e;

    // Byte offsets on the register bus
    localparam int OFS_CTRL    = 0;
    localparam int OFS_TMO     = 8;
    localparam int OFS_RESTART = 12;

    // Control register flag positions
    localparam int BIT_WD_EN  = 18;
    localparam int BIT_RST_EN = 21;
    localparam int BIT_CLK_EN = 24;
    localparam int BIT_DIV_EN = 25;

    // Elapsed count lives in the upper half of the timeout register
    localparam int ELAPSED_LSB = 16;

    typedef struct packed {
        logic div_en;
        logic clk_en;
        logic rst_en;
        logic wd_en;
    } ctrl_flags_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 18,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  elapsed,
    output ctrl_flags_t       flags,
    output logic [DIV_W-1:0]  div_val,
    output logic [CNT_W-1:0]  timeout,
    output logic              restart
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TMO     = ADDR_W'(OFS_TMO);
    localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);

    logic wr_ctrl;
    logic wr_tmo;
    logic unused_bits;

    assign wr_ctrl     = bus_we && (bus_addr == A_CTRL);
    assign wr_tmo      = bus_we && (bus_addr == A_TMO);
    assign restart     = bus_we && (bus_addr == A_RESTART);
    assign unused_bits = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            div_val <= '0;
        end else if (wr_ctrl) begin
            div_val       <= bus_wdata[DIV_W-1:0];
            flags.wd_en   <= bus_wdata[BIT_WD_EN];
            flags.rst_en  <= bus_wdata[BIT_RST_EN];
            flags.clk_en  <= bus_wdata[BIT_CLK_EN];
            flags.div_en  <= bus_wdata[BIT_DIV_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout <= '0;
        end else if (wr_tmo) begin
            timeout <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[DIV_W-1:0]  = div_val;
                bus_rdata[BIT_WD_EN]  = flags.wd_en;
                bus_rdata[BIT_RST_EN] = flags.rst_en;
                bus_rdata[BIT_CLK_EN] = flags.clk_en;
                bus_rdata[BIT_DIV_EN] = flags.div_en;
            end
            A_TMO: begin
                bus_rdata[CNT_W-1:0]                   = timeout;
                bus_rdata[ELAPSED_LSB +: CNT_W]        = elapsed;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    localparam int EXT_W = DIV_W + 1;

    logic [DIV_W-1:0] pcnt;
    logic [EXT_W-1:0] pcnt_inc;
    logic             run;
    logic             last;

    assign run      = clk_en && div_en;
    assign pcnt_inc = {1'b0, pcnt} + EXT_W'(1);
    // A divide value of zero or one degenerates to a tick every cycle
    assign last     = (pcnt_inc >= {1'b0, div_val});
    assign tick     = run && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || last) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt_inc[DIV_W-1:0];
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_en,
    input  logic             rst_en,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] timeout,
    output logic [CNT_W-1:0] elapsed,
    output logic             in_fire,
    output logic             rst_req
);

    wd_state_e state_q;
    wd_state_e state_d;
    logic      match;

    assign match = (elapsed == timeout);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (wd_en) state_d = S_RUN;
            end
            S_RUN: begin
                if (!wd_en)        state_d = S_OFF;
                else if (restart)  state_d = S_RUN;
                else if (match)    state_d = S_FIRE;
            end
            S_FIRE: begin
                state_d = wd_en ? S_RUN : S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    // Elapsed tick counter: restart and expiry both clear it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart || (state_q == S_FIRE)) begin
            elapsed <= '0;
        end else if (wd_en && tick) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        in_fire = (state_q == S_FIRE);
        rst_req = in_fire && rst_en;
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 18,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    ctrl_flags_t      flags;
    logic [DIV_W-1:0] div_val;
    logic [CNT_W-1:0] timeout;
    logic [CNT_W-1:0] elapsed;
    logic             restart;
    logic             tick;
    logic             in_fire;

    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .elapsed(elapsed),
        .flags(flags), .div_val(div_val), .timeout(timeout),
        .restart(restart)
    );

    wdog_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n),
        .clk_en(flags.clk_en), .div_en(flags.div_en),
        .div_val(div_val), .tick(tick)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .wd_en(flags.wd_en), .rst_en(flags.rst_en),
        .tick(tick), .restart(restart), .timeout(timeout),
        .elapsed(elapsed), .in_fire(in_fire), .rst_req(rst_req)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             rst_en,
    input logic             wd_en,
    input logic             restart,
    input logic             fire,
    input logic [CNT_W-1:0] elapsed
);

    // R7: request never lasts longer than one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8: no request while the reset permission is clear
    p_gated_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en |-> !rst_req);

    // R4: restart write leaves the elapsed count at zero
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (elapsed == '0));

    // R9: disarmed counter holds
    p_hold_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && !restart && !fire) |=> (elapsed == $past(elapsed)));

    // R10: restart in a matching cycle prevents the expiry cycle
    p_restart_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fire);

    // R7: expiry clears the count on the next edge
    p_fire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (elapsed == '0));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .rst_en(flags.rst_en), .wd_en(flags.wd_en),
    .restart(restart), .fire(in_fire), .elapsed(elapsed)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int dv, input bit en, input bit rst,
                                            input bit cke, input bit dve);
        logic [31:0] w;
        w = 32'(dv) & 32'h3FFFF;
        w[18] = en; w[21] = rst; w[24] = cke; w[25] = dve;
        return w;
    endfunction

    // Write: returns at the falling edge after the capturing rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic quiesce(input int tmo);
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        wr(4'h8, 32'(tmo));
    endtask

    // Count falling edges until rst_req is seen, from the current one
    task automatic wait_pulse(inout int cnt);
        while (!rst_req && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    initial begin : watchdog
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int cnt;
        int p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h8, v); check("R1 tmo", v, 32'h0);
        rd(4'hC, v); check("R1 restart", v, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);

        // R11 unmapped offset
        rd(4'h4, v); check("R11 offset 4", v, 32'h0);

        // R2 unused control bits read zero
        wr(4'h8, 32'hFFFF);
        bus_addr = 4'h0; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
        @(posedge clk); @(negedge clk); bus_we = 1'b0;
        rd(4'h0, v); check("R2 all ones readback", v, 32'h0327_FFFF);
        quiesce(16'h1234);

        // R3 elapsed field read-only
        wr(4'h8, 32'hABCD_1234);
        rd(4'h8, v); check("R3 tmo write upper ignored", v, 32'h0000_1234);

        // R5 no tick with clock enable clear, then with divider enable clear
        quiesce(100);
        wr(4'h0, mk_ctrl(3, 1, 1, 0, 1));
        repeat (30) @(negedge clk);
        rd(4'h8, v); check("R5 clk_en off", v[31:16], 32'h0);
        quiesce(100);
        wr(4'h0, mk_ctrl(3, 1, 1, 1, 0));
        repeat (30) @(negedge clk);
        rd(4'h8, v); check("R5 div_en off", v[31:16], 32'h0);

        // R6 elapsed count, then R9 hold while disarmed, R2 fields kept
        quiesce(100);
        wr(4'h0, mk_ctrl(4, 1, 1, 1, 1));
        repeat (28) @(negedge clk);
        rd(4'h8, v); check("R6 elapsed after 28 cycles", v, {16'd7, 16'd100});
        wr(4'h0, mk_ctrl(4, 0, 1, 1, 1));
        p0 = pulses;
        repeat (40) @(negedge clk);
        rd(4'h8, v); check("R9 elapsed held", v[31:16], 32'd7);
        check("R9 no pulse disarmed", 32'(pulses - p0), 32'd0);
        rd(4'h0, v); check("R2 fields kept", v, mk_ctrl(4, 0, 1, 1, 1));

        // R4 restart with arbitrary data
        wr(4'hC, 32'hDEAD_BEEF);
        rd(4'h8, v); check("R4 restart clears", v[31:16], 32'h0);

        // R6/R7 sweep over divide value and timeout
        for (int d = 3; d <= 5; d++) begin
            for (int t = 1; t <= 3; t++) begin
                quiesce(t);
                wr(4'h0, mk_ctrl(d, 1, 1, 1, 1));
                cnt = 0;
                wait_pulse(cnt);
                check($sformatf("R6 first pulse d=%0d t=%0d", d, t), 32'(cnt), 32'(t*d + 1));
                @(negedge clk); cnt++;
                check($sformatf("R7 width d=%0d t=%0d", d, t), {31'h0, rst_req}, 32'h0);
                wait_pulse(cnt);
                check($sformatf("R7 period d=%0d t=%0d", d, t), 32'(cnt), 32'(2*t*d + 1));
            end
        end

        // R8 no pulse with permission clear, count still clears at expiry
        quiesce(2);
        p0 = pulses;
        wr(4'h0, mk_ctrl(3, 1, 0, 1, 1));
        repeat (8) @(negedge clk);
        rd(4'h8, v); check("R8 elapsed cleared at expiry", v[31:16], 32'h0);
        repeat (40) @(negedge clk);
        check("R8 no pulse", 32'(pulses - p0), 32'd0);

        // R10 restart meets match
        quiesce(2);
        wr(4'h0, mk_ctrl(5, 1, 1, 1, 1));
        repeat (10) @(negedge clk);
        bus_addr = 4'hC; bus_wdata = 32'h5A5A_0000; bus_we = 1'b1;
        @(posedge clk); @(negedge clk); bus_we = 1'b0;
        check("R10 no pulse after collision", {31'h0, rst_req}, 32'h0);
        cnt = 0;
        wait_pulse(cnt);
        check("R10 pulse delay after restart", 32'(cnt), 32'd10);

        quiesce(0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule